// File: doc/BRIEF.md
# Cascadable Dual Event Counter

This block counts transitions on two external, asynchronous input lines. Each line is brought into the system clock domain, filtered through an edge detector with a selectable active edge, and used to advance its own 16-bit counter. A byte-wide register port gives software one control byte and four counter bytes. Software can read the counters, preload them, or clear them. A capture command freezes all four bytes together so that a multi-byte read stays consistent.

Setting the join bit turns the two counters into one 32-bit counter, advanced by the first input only. Every counted event pulls an open-drain interrupt line low for a fixed time, 100 ms by default. A new event restarts that time. While the counters are joined, the second input raises no interrupt. Software should set the edge polarities before it loads counter values, because a polarity change can itself be counted.

Top module: `evctr_top`

## Requirements
- R1: After reset the control byte reads 0x00, all four counter bytes read 0x00, and `irq_drive_n` is high (idle).
- R2: Control byte at address 0x0C. Bit 0 selects the active edge of input A and bit 1 selects the active edge of input B, with 0 meaning rising and 1 meaning falling. The control byte reads back the value written to bits 2..0. Only the selected edge advances a counter.
- R3: The edge detector works on the input XOR its polarity bit. A polarity change that makes this value go from 0 to 1 counts as one event, exactly like a real edge.
- R4: While bit 2 is 0, counter A (0x0D low byte, 0x0E high byte) counts input A and counter B (0x0F low byte, 0x10 high byte) counts input B. Each counter wraps from 0xFFFF to 0x0000 and leaves the other counter untouched.
- R5: While bit 2 is 1, input A advances a 32-bit value with counter A as the low half and counter B as the high half. Input B changes nothing.
- R6: Writing 1 to bit 3 copies all four live bytes into the holding bytes on the next clock edge. Bit 3 reads 1 until that capture and then clears itself. Counter-byte reads always return the holding bytes, which stay unchanged until the next capture.
- R7: A write to address 0x0D, 0x0E, 0x0F or 0x10 replaces that one live byte with the written data.
- R8: An event detected in the same cycle as a counter-byte write is dropped. Neither counter advances and no interrupt pulse starts.
- R9: Each counted event drives `irq_drive_n` low for exactly CLK_HZ/1000*PULSE_MS cycles. An event during an active pulse restarts the full length.
- R10: While bit 2 is 1, input B transitions do not start an interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in_a | input | 1 | Asynchronous event input A |
| ev_in_b | input | 1 | Asynchronous event input B |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq_drive_n | output | 1 | Low while the open-drain interrupt pin is pulled low |

## Verification
A corrupted live counter stays hidden until the next capture. After that capture it shows as a wrong byte on every counter-byte read. A stale or stuck capture flag shows instead as holding bytes that never follow the live count, or that change between captures. An edge detector that remembers the wrong previous value shows within three cycles of an input change, as an extra or missing count, and as an interrupt pulse that starts or fails to start. A wrong pulse timer shows as a low time that differs from the parameter, or as a pulse that ends early after a retrigger.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    localparam int CW = 16;
    localparam int NB = (2 * CW) / 8;
    localparam int IW = $clog2(NB);

    localparam logic [7:0] A_CTRL = 8'h0C;
    localparam logic [7:0] A_CNT0 = 8'h0D;

    typedef struct packed {
        logic snap;
        logic casc;
        logic pol_b;
        logic pol_a;
    } ctrl_t;

    typedef logic [NB-1:0][7:0] bytes_t;

    function automatic logic cnt_hit(input logic [7:0] a);
        return (a >= A_CNT0) && (32'(a) < 32'(A_CNT0) + NB);
    endfunction

    function automatic logic [IW-1:0] cnt_idx(input logic [7:0] a);
        logic [7:0] d;
        d = a - A_CNT0;
        return d[IW-1:0];
    endfunction

    function automatic int pulse_cycles(input int hz, input int ms);
        return (hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/evctr_edge.sv
module evctr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic pol,
    output logic evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;
    logic                   cur;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign cur = sync_q[SYNC_STAGES-1] ^ pol;
    assign evt = cur & ~seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= cur;
    end

    // R3: a reported event leaves the remembered value at 1
    assert_evt_level_R3: assert property (@(posedge clk) disable iff (rst)
        evt |=> seen_q);

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_a,
    input  logic          evt_b,
    input  logic          casc,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          snap,
    output bytes_t        hold,
    output logic          counted
);
    logic [2*CW-1:0] live_q;
    bytes_t          hold_q;
    logic [CW-1:0]   c_lo, c_hi;
    logic            inc_lo, inc_hi;

    assign c_lo   = live_q[CW-1:0];
    assign c_hi   = live_q[2*CW-1:CW];
    assign inc_lo = evt_a & ~wr_en;
    assign inc_hi = casc ? (inc_lo & (&c_lo)) : (evt_b & ~wr_en);
    assign counted = inc_lo | (evt_b & ~wr_en & ~casc);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (wr_en) begin
            live_q[32'(wr_idx)*8 +: 8] <= wr_data;
        end else begin
            live_q <= {c_hi + CW'(inc_hi), c_lo + CW'(inc_lo)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (snap) hold_q <= bytes_t'(live_q);
    end

    assign hold = hold_q;

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!casc && !wr_en && evt_a && (&c_lo)) |=> (c_lo == '0));

    assert_b_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (casc && !wr_en && !(evt_a && (&c_lo))) |=> (c_hi == $past(c_hi)));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(hold_q));

    assert_write_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == '0) |=> (c_lo[CW-1:8] == $past(c_lo[CW-1:8])));

endmodule

// File: rtl/evctr_pulse.sv
module evctr_pulse #(
    parameter int LEN = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic out_n
);
    localparam int TW = $clog2(LEN + 1);

    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst)              tmr_q <= '0;
        else if (trig)        tmr_q <= TW'(LEN);
        else if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
    end

    assign out_n = (tmr_q == '0);

    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> !out_n);

    assert_timer_bound_R9: assert property (@(posedge clk) disable iff (rst)
        tmr_q <= TW'(LEN));

endmodule

// File: rtl/evctr_top.sv
module evctr_top
    import evctr_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PULSE_MS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_in_a,
    input  logic       ev_in_b,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_drive_n
);
    localparam int PULSE_LEN = pulse_cycles(CLK_HZ, PULSE_MS);

    ctrl_t        ctrl_q;
    logic [1:0]   pins, pols, evts;
    bytes_t       hold;
    logic         counted;
    logic         wr_ctrl, wr_cnt;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_cnt  = reg_wr && cnt_hit(reg_addr);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[3:0]);
        else if (ctrl_q.snap) ctrl_q.snap <= 1'b0;
    end

    assign pins = {ev_in_b, ev_in_a};
    assign pols = {ctrl_q.pol_b, ctrl_q.pol_a};

    for (genvar i = 0; i < 2; i++) begin : g_in
        evctr_edge #(.SYNC_STAGES(2)) u_edge (
            .clk (clk),
            .rst (rst),
            .pin (pins[i]),
            .pol (pols[i]),
            .evt (evts[i])
        );
    end

    evctr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt_a   (evts[0]),
        .evt_b   (evts[1]),
        .casc    (ctrl_q.casc),
        .wr_en   (wr_cnt),
        .wr_idx  (cnt_idx(reg_addr)),
        .wr_data (reg_wdata),
        .snap    (ctrl_q.snap),
        .hold    (hold),
        .counted (counted)
    );

    evctr_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (counted),
        .out_n (irq_drive_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)      reg_rdata = {4'b0, ctrl_q};
        else if (cnt_hit(reg_addr))  reg_rdata = hold[cnt_idx(reg_addr)];
    end

    assert_snap_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.snap && !wr_ctrl) |=> !ctrl_q.snap);

    assert_casc_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.casc && !evts[0] && irq_drive_n) |=> irq_drive_n);

endmodule

// File: tb/evctr_top_tb.sv
module evctr_top_tb_top;

    typedef struct {
        logic [7:0] a;
        logic [7:0] e;
        string      tag;
    } rd_item_t;

    localparam int PLEN = 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ina = 1'b0, inb = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    rd_item_t q[$];
    logic [15:0] e1 = '0, e2 = '0;
    logic [7:0]  cv = '0;

    always #10 clk = ~clk;

    evctr_top #(.CLK_HZ(10_000), .PULSE_MS(100)) dut_i (
        .clk (clk), .rst (rst), .ev_in_a (ina), .ev_in_b (inb),
        .reg_addr (addr), .reg_wr (wr), .reg_wdata (wdata),
        .reg_rdata (rdata), .irq_drive_n (irq_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expected reads and compares
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            rd_item_t it;
            it = q.pop_front();
            check(rdata == it.e, it.tag, rdata, it.e);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rexp(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        q.push_back('{a: a, e: e, tag: tag});
        @(negedge clk);
    endtask

    task automatic capture();
        @(negedge clk);
        addr = 8'h0C; wdata = cv | 8'h08; wr = 1'b1;
        @(posedge clk);
        #1 check(rdata[3] == 1'b1, "R6 flag set", rdata, cv | 8'h08);
        @(negedge clk);
        wr = 1'b0;
        tick(2);
        rexp(8'h0C, cv, "R6 flag self-clear");
    endtask

    task automatic readall(input string tag);
        capture();
        rexp(8'h0D, e1[7:0], tag);
        rexp(8'h0E, e1[15:8], tag);
        rexp(8'h0F, e2[7:0], tag);
        rexp(8'h10, e2[15:8], tag);
    endtask

    task automatic pulse_a();
        @(negedge clk); ina = 1'b1; tick(4);
        ina = 1'b0; tick(4);
    endtask

    task automatic wait_idle();
        while (!irq_n) @(negedge clk);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        tick(3);
        rst = 1'b0;
        tick(1);
        check(irq_n == 1'b1, "R1 irq idle", irq_n, 1);
        rexp(8'h0C, 8'h00, "R1 ctrl");
        for (int a = 8'h0D; a <= 8'h10; a++) rexp(8'(a), 8'h00, "R1 counters");

        // R2/R4: rising edges on A count
        repeat (3) pulse_a();
        e1 = 3;
        check(irq_n == 1'b0, "R9 pulse active", irq_n, 0);
        readall("R4 independent");

        // R6: holding bytes stay until next capture
        repeat (2) pulse_a();
        e1 = 5;
        rexp(8'h0D, 8'h03, "R6 hold stable");
        readall("R6 new capture");

        // R3: polarity change with B low counts once; R2 falling edge
        cv = 8'h02;
        wreg(8'h0C, cv); tick(4);
        e2 = 1;
        @(negedge clk); inb = 1'b1; tick(4);
        inb = 1'b0; tick(4);
        e2 = 2;
        rexp(8'h0C, 8'h02, "R2 ctrl readback");
        readall("R3 R2 polarity");

        // R4 wrap of counter A
        wreg(8'h0D, 8'hFF); wreg(8'h0E, 8'hFF);
        pulse_a();
        e1 = 0;
        readall("R4 wrap");

        // R7 preload
        wreg(8'h0F, 8'h34); wreg(8'h10, 8'h12);
        e2 = 16'h1234;
        readall("R7 preload");

        // R8 event coincides with counter write
        wait_idle();
        @(negedge clk); ina = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 8'h0E; wdata = 8'h55; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check(irq_n == 1'b1, "R8 no pulse", irq_n, 1);
        ina = 1'b0; tick(4);
        e1 = 16'h5500;
        readall("R8 dropped event");

        // R5 cascade
        cv = 8'h06;
        wreg(8'h0C, cv);
        wreg(8'h0D, 8'hFF); wreg(8'h0E, 8'hFF);
        e1 = 16'hFFFF;
        pulse_a();
        e1 = 16'h0000; e2 = 16'h1235;
        readall("R5 carry");
        wait_idle();
        @(negedge clk); inb = 1'b1; tick(4);
        inb = 1'b0; tick(4);
        check(irq_n == 1'b1, "R10 B silent", irq_n, 1);
        readall("R5 B ignored");

        // R9 exact length
        cv = 8'h02;
        wreg(8'h0C, cv);
        wait_idle();
        @(negedge clk); ina = 1'b1;
        while (irq_n) @(negedge clk);
        n = 0;
        while (!irq_n) begin n++; @(negedge clk); end
        check(n == PLEN, "R9 length", n, PLEN);

        // R9 retrigger
        ina = 1'b0; tick(4);
        @(negedge clk); ina = 1'b1;
        while (irq_n) @(negedge clk);
        tick(600);
        ina = 1'b0; tick(4);
        ina = 1'b1; tick(4);
        tick(600);
        check(irq_n == 1'b0, "R9 retrigger", irq_n, 0);
        wait_idle();
        check(irq_n == 1'b1, "R9 ends", irq_n, 1);

        tick(3);
        report();
    end

endmodule